// File: doc/BRIEF.md
# Micro Translation Cache

This block is a tiny, fully associative store of recent virtual-to-physical page translations that a processor core consults before going to its main TLB. It holds two independent sets of entries, one serving instruction fetches and one serving data loads and stores. Each entry maps one 4 KB virtual page to a physical page base. Each entry also records how much access the mapping allows: read only, or read and write.

A lookup is combinational. The core presents a virtual address, whether the access is a fetch, and whether it is a write. In the same cycle the block answers with a hit flag, the physical address and the stored access level. Addresses in the directly mapped kernel window never hit, so the core always translates them by its fixed rule. After the main TLB has resolved a miss, the core writes the translation through the fill port. The fill overwrites a victim chosen in turn within the selected set. A flush input empties both sets, for example when the address space identifier or a mapping changes.

Top module: `micro_xlate_cache`

## Requirements
- R1: A lookup whose address bits [31:30] equal 2'b10 always misses, even if a matching page has been filled.
- R2: A fetch (`lk_is_instr`=1) searches only the instruction set; a data access searches only the data set; a fill goes only to the set named by `fill_is_instr`.
- R3: A fill stores level 2 (read/write) when `fill_dirty`=1 and level 1 (read only) otherwise; on a hit `lk_level` returns the stored level.
- R4: A lookup requires level 1 for a read and level 2 for a write, and hits only on a valid entry whose level is at least the required level and whose page number equals vaddr[31:12].
- R5: On a hit `lk_paddr` is {stored physical page, vaddr[11:0]}; on a miss `lk_hit`, `lk_paddr` and `lk_level` are all zero.
- R6: When several valid entries of the searched set qualify, the lowest-numbered entry supplies the result.
- R7: Each set has 4 entries and its own victim pointer; after reset or flush the pointer is 0, each fill writes the pointed entry and advances the pointer by one, wrapping from 3 to 0, so the fifth fill replaces the first.
- R8: A flush empties both sets and resets both pointers in one cycle; a fill in the same cycle as a flush is discarded.
- R9: After reset every lookup misses.
- R10: A fill becomes visible to lookups from the next cycle; a lookup in the fill cycle sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty both sets |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_is_instr | input | 1 | 1 = fetch, 0 = data access |
| lk_is_write | input | 1 | 1 = write, 0 = read |
| lk_hit | output | 1 | Translation found |
| lk_paddr | output | 32 | Translated physical address |
| lk_level | output | 2 | Stored access level of the hit |
| fill_en | input | 1 | Write a translation |
| fill_is_instr | input | 1 | Target set: 1 = instruction, 0 = data |
| fill_vpn | input | 20 | Virtual page number to store |
| fill_pfn | input | 20 | Physical page number to store |
| fill_dirty | input | 1 | Source translation writable |

## Verification
The hardest case to reach from the ports is an entry that does not qualify while a higher-numbered duplicate does. This happens when the same page sits twice in one set with a read-only copy below a writable one, and a write then arrives. Directed fills build exactly that layout. The random phase keeps draws to a pool of six pages, so that fills to the same page are frequent. It also mixes in a flush and concurrent fill-and-lookup cycles, so that wraparound, duplicate entries and old-content reads happen many times.

// File: rtl/utc_pkg.sv
package utc_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 32;
  localparam int OFS_W     = 12;
  localparam int LVL_W     = 2;
  localparam logic [LVL_W-1:0] LVL_NONE = 2'd0;
  localparam logic [LVL_W-1:0] LVL_RD   = 2'd1;
  localparam logic [LVL_W-1:0] LVL_RW   = 2'd2;
endpackage

// File: rtl/utc_entry.sv
module utc_entry
  import utc_pkg::*;
#(
  parameter int VPN_W = 20,
  parameter int PFN_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic [VPN_W-1:0] cmp_vpn,
  input  logic [LVL_W-1:0] req_lvl,
  output logic             qual,
  output logic [PFN_W-1:0] pfn,
  output logic [LVL_W-1:0] lvl
);
  logic             valid_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PFN_W-1:0] pfn_q;
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= 1'b0;
    end else if (wr_en) begin
      valid_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) begin
      vpn_q <= wr_vpn;
      pfn_q <= wr_pfn;
      lvl_q <= wr_lvl;
    end
  end

  assign qual = valid_q && (vpn_q == cmp_vpn) && (lvl_q >= req_lvl);
  assign pfn  = pfn_q;
  assign lvl  = lvl_q;

  AST_ENTRY_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !qual); // R8
endmodule

// File: rtl/utc_array.sv
module utc_array
  import utc_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic [LVL_W-1:0] fill_lvl,
  input  logic             lk_en,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [LVL_W-1:0] lk_req,
  output logic             hit,
  output logic [PFN_W-1:0] hit_pfn,
  output logic [LVL_W-1:0] hit_lvl
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [ENTRIES-1:0] qual;
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [LVL_W-1:0]   e_lvl [ENTRIES];
  logic               do_fill;

  assign do_fill = fill_en && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ptr_q <= '0;
    end else if (fill_en) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    utc_entry #(.VPN_W(VPN_W), .PFN_W(PFN_W)) i_entry (
      .clk     (clk),
      .rst     (rst),
      .clr     (flush),
      .wr_en   (do_fill && (ptr_q == PTR_W'(g))),
      .wr_vpn  (fill_vpn),
      .wr_pfn  (fill_pfn),
      .wr_lvl  (fill_lvl),
      .cmp_vpn (lk_vpn),
      .req_lvl (lk_req),
      .qual    (qual[g]),
      .pfn     (e_pfn[g]),
      .lvl     (e_lvl[g])
    );
  end

  always_comb begin
    hit     = 1'b0;
    hit_pfn = '0;
    hit_lvl = LVL_NONE;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_en && qual[i]) begin
        hit     = 1'b1;
        hit_pfn = e_pfn[i];
        hit_lvl = e_lvl[i];
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fill_en && !flush) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1))); // R7
  AST_PTR_HOME: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ptr_q == '0)); // R8
  AST_HIT_SUFFICES: assert property (@(posedge clk) disable iff (rst)
    hit |-> (hit_lvl >= lk_req && hit_lvl != LVL_NONE)); // R4
endmodule

// File: rtl/micro_xlate_cache.sv
module micro_xlate_cache
  import utc_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   flush,
  input  logic [VA_W-1:0]        lk_vaddr,
  input  logic                   lk_is_instr,
  input  logic                   lk_is_write,
  output logic                   lk_hit,
  output logic [PA_W-1:0]        lk_paddr,
  output logic [LVL_W-1:0]       lk_level,
  input  logic                   fill_en,
  input  logic                   fill_is_instr,
  input  logic [VA_W-OFS_W-1:0]  fill_vpn,
  input  logic [PA_W-OFS_W-1:0]  fill_pfn,
  input  logic                   fill_dirty
);
  localparam int VPN_W = VA_W - OFS_W;
  localparam int PFN_W = PA_W - OFS_W;
  localparam int SETS  = 2;

  logic             in_window;
  logic [LVL_W-1:0] req_lvl;
  logic [LVL_W-1:0] fill_lvl;
  logic [SETS-1:0]  s_hit;
  logic [PFN_W-1:0] s_pfn [SETS];
  logic [LVL_W-1:0] s_lvl [SETS];
  logic             sel;

  assign in_window = (lk_vaddr[VA_W-1 -: 2] == 2'b10);
  assign req_lvl   = lk_is_write ? LVL_RW : LVL_RD;
  assign fill_lvl  = fill_dirty ? LVL_RW : LVL_RD;
  assign sel       = lk_is_instr;

  // set 0 = data, set 1 = instruction
  for (genvar s = 0; s < SETS; s++) begin : g_set
    utc_array #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) i_arr (
      .clk      (clk),
      .rst      (rst),
      .flush    (flush),
      .fill_en  (fill_en && (fill_is_instr == (s == 1))),
      .fill_vpn (fill_vpn),
      .fill_pfn (fill_pfn),
      .fill_lvl (fill_lvl),
      .lk_en    (!in_window && (lk_is_instr == (s == 1))),
      .lk_vpn   (lk_vaddr[VA_W-1:OFS_W]),
      .lk_req   (req_lvl),
      .hit      (s_hit[s]),
      .hit_pfn  (s_pfn[s]),
      .hit_lvl  (s_lvl[s])
    );
  end

  assign lk_hit   = s_hit[sel];
  assign lk_paddr = s_hit[sel] ? {s_pfn[sel], lk_vaddr[OFS_W-1:0]} : '0;
  assign lk_level = s_hit[sel] ? s_lvl[sel] : LVL_NONE;

  AST_WINDOW_MISS: assert property (@(posedge clk) disable iff (rst)
    in_window |-> !lk_hit); // R1
  AST_ONE_SET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_hit)); // R2
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_paddr == '0 && lk_level == LVL_NONE)); // R5
  AST_WRITE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (lk_hit && lk_is_write) |-> lk_level == LVL_RW); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]); // R5
endmodule

// File: tb/test_micro_xlate_cache.sv
module test_micro_xlate_cache;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_is_instr = 1'b0;
  logic        lk_is_write = 1'b0;
  logic        lk_hit;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_level;
  logic        fill_en = 1'b0;
  logic        fill_is_instr = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic        fill_dirty = 1'b0;

  int tests = 0;
  int fails = 0;

  // bench model: [set][entry], set 1 = instruction
  logic        m_v   [2][4];
  logic [19:0] m_vpn [2][4];
  logic [19:0] m_pfn [2][4];
  logic [1:0]  m_lvl [2][4];
  int          m_ptr [2];

  always #5 clk = ~clk;

  micro_xlate_cache i_micro_xlate_cache (
    .clk(clk), .rst(rst), .flush(flush),
    .lk_vaddr(lk_vaddr), .lk_is_instr(lk_is_instr), .lk_is_write(lk_is_write),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_level(lk_level),
    .fill_en(fill_en), .fill_is_instr(fill_is_instr), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_dirty(fill_dirty)
  );

  function automatic logic [34:0] expect_lookup(logic [31:0] va, logic ins, logic wr);
    logic [1:0] need;
    int s;
    need = wr ? 2'd2 : 2'd1;
    s = ins ? 1 : 0;
    if (va[31:30] == 2'b10) return '0;
    for (int i = 0; i < 4; i++) begin
      if (m_v[s][i] && m_vpn[s][i] == va[31:12] && m_lvl[s][i] >= need)
        return {1'b1, m_pfn[s][i], va[11:0], m_lvl[s][i]};
    end
    return '0;
  endfunction

  task automatic model_reset();
    for (int s = 0; s < 2; s++) begin
      m_ptr[s] = 0;
      for (int i = 0; i < 4; i++) m_v[s][i] = 1'b0;
    end
  endtask

  task automatic model_clock();
    int s;
    if (flush) model_reset();
    else if (fill_en) begin
      s = fill_is_instr ? 1 : 0;
      m_v[s][m_ptr[s]]   = 1'b1;
      m_vpn[s][m_ptr[s]] = fill_vpn;
      m_pfn[s][m_ptr[s]] = fill_pfn;
      m_lvl[s][m_ptr[s]] = fill_dirty ? 2'd2 : 2'd1;
      m_ptr[s] = (m_ptr[s] + 1) % 4;
    end
  endtask

  // one cycle: apply inputs at negedge, check the combinational result, then clock
  task automatic cycle(input logic [31:0] va, input logic ins, input logic wr,
                       input logic fe, input logic fi, input logic [19:0] fv,
                       input logic [19:0] fp, input logic fd, input logic fl,
                       input string tag);
    logic [34:0] e;
    @(negedge clk);
    lk_vaddr = va; lk_is_instr = ins; lk_is_write = wr;
    fill_en = fe; fill_is_instr = fi; fill_vpn = fv; fill_pfn = fp;
    fill_dirty = fd; flush = fl;
    #1;
    e = expect_lookup(va, ins, wr);
    tests++;
    if ({lk_hit, lk_paddr, lk_level} !== e) begin
      fails++;
      $display("FAIL %s va=%h got hit=%b pa=%h lvl=%0d exp hit=%b pa=%h lvl=%0d",
               tag, va, lk_hit, lk_paddr, lk_level, e[34], e[33:2], e[1:0]);
    end
    @(posedge clk);
    model_clock();
  endtask

  task automatic fill(input logic fi, input logic [19:0] fv, input logic [19:0] fp,
                      input logic fd, input string tag);
    cycle({fv, 12'h000}, fi, 1'b0, 1'b1, fi, fv, fp, fd, 1'b0, tag);
  endtask

  task automatic look(input logic [31:0] va, input logic ins, input logic wr, input string tag);
    cycle(va, ins, wr, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : stim
    logic [19:0] pool [6];
    process::self().srandom(32'd2024);
    pool[0] = 20'h00010; pool[1] = 20'h00011; pool[2] = 20'h3ffff;
    pool[3] = 20'h80123; pool[4] = 20'hc0004; pool[5] = 20'h7ffff;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R9: empty after reset
    look(32'h0001_0abc, 1'b0, 1'b0, "R9 reset data");
    look(32'h0001_0abc, 1'b1, 1'b0, "R9 reset instr");

    // R10: fill and lookup in the same cycle see old contents
    cycle(32'h0001_0123, 1'b0, 1'b0, 1'b1, 1'b0, 20'h00010, 20'hAAAAA, 1'b0, 1'b0, "R10 same cycle");
    look(32'h0001_0123, 1'b0, 1'b0, "R10 next cycle R5 paddr R3 level1");
    look(32'h0001_0123, 1'b0, 1'b1, "R4 write to read-only");
    look(32'h0001_0123, 1'b1, 1'b0, "R2 instr does not see data");

    // R3: dirty fill gives level 2
    fill(1'b1, 20'h00020, 20'h12345, 1'b1, "R3 fill");
    look(32'h0002_0fff, 1'b1, 1'b1, "R3 level2 write R2 instr");
    look(32'h0002_0fff, 1'b0, 1'b0, "R2 data does not see instr");

    // R1: window address never hits
    fill(1'b0, 20'h80001, 20'h00001, 1'b1, "R1 fill");
    look(32'h8000_1004, 1'b0, 1'b0, "R1 window miss");

    // R6: read-only copy below writable copy of same page
    fill(1'b0, 20'h00055, 20'h11111, 1'b0, "R6 fill ro");  // data entry 2
    fill(1'b0, 20'h00055, 20'h22222, 1'b1, "R6 fill rw");  // data entry 3
    look(32'h0005_5010, 1'b0, 1'b0, "R6 read takes lower");
    look(32'h0005_5010, 1'b0, 1'b1, "R6 write skips to upper");

    // R7: fifth fill of data set replaces entry 0 (page 0x00010)
    fill(1'b0, 20'h00099, 20'h33333, 1'b0, "R7 wrap fill");
    look(32'h0001_0123, 1'b0, 1'b0, "R7 evicted");
    look(32'h0009_9123, 1'b0, 1'b0, "R7 new entry");

    // R8: flush with concurrent fill drops everything
    cycle(32'h0002_0000, 1'b1, 1'b0, 1'b1, 1'b1, 20'h00077, 20'h44444, 1'b1, 1'b1, "R8 flush cycle");
    look(32'h0002_0000, 1'b1, 1'b0, "R8 instr empty");
    look(32'h0007_7000, 1'b1, 1'b0, "R8 dropped fill");
    look(32'h0005_5000, 1'b0, 1'b0, "R8 data empty");
    fill(1'b0, 20'h00066, 20'h55555, 1'b1, "R8 pointer home");
    look(32'h0006_6000, 1'b0, 1'b1, "R8 refill");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [19:0] pv;
      r  = $urandom;
      pv = pool[$urandom % 6];
      cycle({pool[$urandom % 6], r[11:0]}, r[12], r[13],
            (r[17:14] < 4'd5), r[18], pv, {r[31:20], r[7:0]}, r[19],
            (r[27:20] == 8'd0), "R4 R5 R6 R7 random");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule